// File: doc/BRIEF.md
# Privilege-Segmented Virtual Address Front-End

This block takes a 32-bit virtual address and the current privilege context, and decides in the same cycle how that address is to be resolved. The address space is split into fixed regions by its three most significant bits. Some regions pass straight through to a physical address with a constant offset removed. Others have to be looked up in an external translation buffer, which returns a status and a physical address in the same cycle. Each region is open only to certain privilege levels. An error-level flag lets the lowest region bypass translation altogether.

When an access fails, the block reports one exception class. The causes are: the region is closed to the current mode, the translation buffer has no matching entry, the entry is invalid, or a write hits a clean page. For a missing entry the block also raises a refill flag. The same failure, when a request strobe qualifies it, loads three fault-register images on the next clock edge: the offending address, a context word and an entry-high word. Software-visible register files outside the block can copy those images when the one-cycle fault strobe is high.

Top module: `vaddr_seg_front`

## Requirements
- R1: Privilege mode encoding is 0 = user, 1 = supervisor, 2 or 3 = kernel. Buffer status encoding is 0 = hit, 1 = no match, 2 = invalid, 3 = dirty. With the error-level flag clear, an address below 0x80000000 requests a lookup (`tlbLookup` = 1) in every mode. On a hit, `physAddr` equals `tlbPhys`, read permission is granted, and write permission follows `tlbWrOk`.
- R2: With the error-level flag set, an address below 0x80000000 maps to itself with read and write permission and no lookup. The buffer status has no effect on it. For addresses at or above 0x80000000 the flag changes nothing.
- R3: Addresses 0x80000000–0x9FFFFFFF are open to kernel mode only and translate to the address minus 0x80000000, with read and write permission.
- R4: Addresses 0xA0000000–0xBFFFFFFF are open to kernel mode only and translate to the address minus 0xA0000000, with read and write permission.
- R5: Addresses 0xC0000000–0xDFFFFFFF go through the buffer in supervisor or kernel mode. Addresses 0xE0000000–0xFFFFFFFF go through it in kernel mode only.
- R6: An access to a region closed to the current mode raises exception class 1 (address error, load) for a read or class 2 (address error, store) for a write, with no lookup. Class 0 means no exception.
- R7: A lookup returning no match raises class 3 (buffer load) for a read or class 4 (buffer store) for a write, with `refill` = 1. An invalid status raises the same classes with `refill` = 0.
- R8: A lookup returning dirty status raises class 5 (modify) for both reads and writes.
- R9: Every faulting access while `reqValid` is high loads the full address into `badAddrOut` and pulses `faultStrobe` high for exactly the following cycle. Whenever an exception is raised, `physAddr` is 0 and both permissions are 0.
- R10: On a captured fault, `contextOut` keeps bits 31:23 of `curContext`, holds address bits 31:13 in bits 22:4, and has bits 3:0 at zero.
- R11: On a captured fault, `entryHiOut` keeps bits 7:0 of `curEntryHi`, holds address bits 31:13 in bits 31:13, and has bits 12:8 at zero.
- R12: If no fault is raised, or `reqValid` is low, the three fault images hold their values and `faultStrobe` is 0.
- R13: During reset, the fault images are 0 and `faultStrobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Qualifies the access for fault capture |
| vaddr | input | 32 | Virtual address |
| isWrite | input | 1 | 1 = store, 0 = load |
| privMode | input | 2 | Privilege mode (0 user, 1 supervisor, 2/3 kernel) |
| errLevel | input | 1 | Error-level flag, bypasses the low region |
| tlbStatus | input | 2 | Buffer result (0 hit, 1 no match, 2 invalid, 3 dirty) |
| tlbPhys | input | 32 | Physical address from the buffer on a hit |
| tlbWrOk | input | 1 | Hit entry is writable |
| curContext | input | 32 | Present context register value |
| curEntryHi | input | 32 | Present entry-high register value |
| tlbLookup | output | 1 | Address is in a region that needs the buffer |
| physAddr | output | 32 | Translated physical address, 0 on exception |
| permRead | output | 1 | Read permitted |
| permWrite | output | 1 | Write permitted |
| excValid | output | 1 | An exception is raised |
| excClass | output | 3 | Exception class (0 none … 5 modify) |
| refill | output | 1 | Exception came from a missing buffer entry |
| faultStrobe | output | 1 | Fault images were updated on the last edge |
| badAddrOut | output | 32 | Faulting address image |
| contextOut | output | 32 | Context write image |
| entryHiOut | output | 32 | Entry-high write image |

## Verification
The in-RTL properties check several things on every clock. A user-mode access above the low region always yields an address error. A refill indication appears only with a no-match status on a looked-up address. An exception never grants a permission. The fault images either hold or capture exactly the qualified address with the preserved ID and context bits. What properties cannot show is whether the offsets for each region, the per-mode openness of every region, and the class chosen for each status and direction combination are correct. Those are shown by the bench, which drives random and boundary addresses against an independent reference model and compares every output.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

  typedef enum logic [1:0] {
    MODE_USER  = 2'd0,
    MODE_SUPER = 2'd1,
    MODE_KERN  = 2'd2,
    MODE_KERN2 = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    TLB_HIT     = 2'd0,
    TLB_MISS    = 2'd1,
    TLB_INVALID = 2'd2,
    TLB_DIRTY   = 2'd3
  } tlb_e;

  typedef enum logic [2:0] {
    EXC_NONE    = 3'd0,
    EXC_ADDR_LD = 3'd1,
    EXC_ADDR_ST = 3'd2,
    EXC_TLB_LD  = 3'd3,
    EXC_TLB_ST  = 3'd4,
    EXC_TLB_MOD = 3'd5
  } exc_e;

  typedef enum logic [2:0] {
    PSRC_ZERO    = 3'd0,
    PSRC_BYPASS  = 3'd1,
    PSRC_WINLO   = 3'd2,
    PSRC_WINHI   = 3'd3,
    PSRC_TLB     = 3'd4
  } psrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    psrc_e physSrc;
    logic  permRd;
    logic  permWr;
    logic  faultCapture;
  } ctrl_strobe_t;

endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [2:0]   segBits,
  input  logic         isWrite,
  input  priv_e        privMode,
  input  logic         errLevel,
  input  tlb_e         tlbStatus,
  input  logic         tlbWrOk,
  output ctrl_strobe_t strobe,
  output exc_e         excClass,
  output logic         refill,
  output logic         tlbLookup
);

  logic isKernel;
  logic isSuper;
  logic denied;
  logic mapped;
  psrc_e directSrc;
  logic  directHit;

  assign isKernel = (privMode == MODE_KERN) || (privMode == MODE_KERN2);
  assign isSuper  = (privMode == MODE_SUPER);

  // Region classification by the top three address bits
  always_comb begin
    denied    = 1'b0;
    mapped    = 1'b0;
    directHit = 1'b0;
    directSrc = PSRC_ZERO;
    unique casez (segBits)
      3'b0??: begin
        if (errLevel) begin
          directHit = 1'b1;
          directSrc = PSRC_BYPASS;
        end else begin
          mapped = 1'b1;
        end
      end
      3'b100: begin
        directHit = isKernel;
        directSrc = PSRC_WINLO;
        denied    = !isKernel;
      end
      3'b101: begin
        directHit = isKernel;
        directSrc = PSRC_WINHI;
        denied    = !isKernel;
      end
      3'b110: begin
        mapped = isKernel || isSuper;
        denied = !(isKernel || isSuper);
      end
      default: begin
        mapped = isKernel;
        denied = !isKernel;
      end
    endcase
  end

  // Outcome resolution
  always_comb begin
    strobe.physSrc = PSRC_ZERO;
    strobe.permRd  = 1'b0;
    strobe.permWr  = 1'b0;
    excClass       = EXC_NONE;
    refill         = 1'b0;
    if (denied) begin
      excClass = isWrite ? EXC_ADDR_ST : EXC_ADDR_LD;
    end else if (directHit) begin
      strobe.physSrc = directSrc;
      strobe.permRd  = 1'b1;
      strobe.permWr  = 1'b1;
    end else if (mapped) begin
      unique case (tlbStatus)
        TLB_HIT: begin
          strobe.physSrc = PSRC_TLB;
          strobe.permRd  = 1'b1;
          strobe.permWr  = tlbWrOk;
        end
        TLB_MISS: begin
          excClass = isWrite ? EXC_TLB_ST : EXC_TLB_LD;
          refill   = 1'b1;
        end
        TLB_INVALID: begin
          excClass = isWrite ? EXC_TLB_ST : EXC_TLB_LD;
        end
        default: begin
          excClass = EXC_TLB_MOD;
        end
      endcase
    end
  end

  assign tlbLookup           = mapped;
  assign strobe.faultCapture = reqValid && (excClass != EXC_NONE);

  AST_USER_HIGH_DENIED: assert property (@(posedge clk) disable iff (!rstN)
    (privMode == MODE_USER && segBits[2]) |->
      (excClass == EXC_ADDR_LD || excClass == EXC_ADDR_ST)); // R6

  AST_REFILL_ONLY_MISS: assert property (@(posedge clk) disable iff (!rstN)
    refill |-> (tlbLookup && tlbStatus == TLB_MISS)); // R7

  AST_DIRTY_IS_MODIFY: assert property (@(posedge clk) disable iff (!rstN)
    (tlbLookup && tlbStatus == TLB_DIRTY) |-> excClass == EXC_TLB_MOD); // R8

  AST_NO_PERM_ON_EXC: assert property (@(posedge clk) disable iff (!rstN)
    (excClass != EXC_NONE) |-> (!strobe.permRd && !strobe.permWr &&
                                strobe.physSrc == PSRC_ZERO)); // R9

  AST_BYPASS_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    (errLevel && !segBits[2]) |-> (!tlbLookup && excClass == EXC_NONE)); // R2

endmodule

// File: rtl/segdec_dp.sv
module segdec_dp
  import segdec_pkg::*;
#(
  parameter int AddrWidth  = 32,
  parameter int IdWidth    = 8,
  parameter int PairShift  = 13,
  parameter int CtxLsb     = 4,
  parameter logic [AddrWidth-1:0] WinLoBase = 32'h8000_0000,
  parameter logic [AddrWidth-1:0] WinHiBase = 32'hA000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strobe,
  input  logic [AddrWidth-1:0] vaddr,
  input  logic [AddrWidth-1:0] tlbPhys,
  input  logic [AddrWidth-1:0] curContext,
  input  logic [AddrWidth-1:0] curEntryHi,
  output logic [AddrWidth-1:0] physAddr,
  output logic                 permRead,
  output logic                 permWrite,
  output logic                 faultStrobe,
  output logic [AddrWidth-1:0] badAddrOut,
  output logic [AddrWidth-1:0] contextOut,
  output logic [AddrWidth-1:0] entryHiOut
);

  localparam int VpnWidth = AddrWidth - PairShift;
  localparam int CtxTop   = CtxLsb + VpnWidth;

  localparam logic [AddrWidth-1:0] CtxKeepMask = ~((AddrWidth'(1) << CtxTop) - AddrWidth'(1));
  localparam logic [AddrWidth-1:0] IdKeepMask  = (AddrWidth'(1) << IdWidth) - AddrWidth'(1);
  localparam logic [AddrWidth-1:0] PairMask    = ~((AddrWidth'(1) << PairShift) - AddrWidth'(1));

  logic [AddrWidth-1:0] ctxField;
  logic [AddrWidth-1:0] nextContext;
  logic [AddrWidth-1:0] nextEntryHi;

  always_comb begin
    unique case (strobe.physSrc)
      PSRC_BYPASS: physAddr = vaddr;
      PSRC_WINLO:  physAddr = vaddr - WinLoBase;
      PSRC_WINHI:  physAddr = vaddr - WinHiBase;
      PSRC_TLB:    physAddr = tlbPhys;
      default:     physAddr = '0;
    endcase
  end

  assign permRead  = strobe.permRd;
  assign permWrite = strobe.permWr;

  assign ctxField    = AddrWidth'(vaddr[AddrWidth-1:PairShift]) << CtxLsb;
  assign nextContext = (curContext & CtxKeepMask) | ctxField;
  assign nextEntryHi = (curEntryHi & IdKeepMask) | (vaddr & PairMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultStrobe <= 1'b0;
      badAddrOut  <= '0;
      contextOut  <= '0;
      entryHiOut  <= '0;
    end else begin
      faultStrobe <= strobe.faultCapture;
      if (strobe.faultCapture) begin
        badAddrOut <= vaddr;
        contextOut <= nextContext;
        entryHiOut <= nextEntryHi;
      end
    end
  end

  AST_BADADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.faultCapture |=> (faultStrobe && badAddrOut == $past(vaddr))); // R9

  AST_IMAGES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.faultCapture |=> (!faultStrobe && $stable(badAddrOut) &&
                              $stable(contextOut) && $stable(entryHiOut))); // R12

  AST_ENTRYHI_ID_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.faultCapture |=>
      entryHiOut[IdWidth-1:0] == $past(curEntryHi[IdWidth-1:0])); // R11

  AST_CTX_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.faultCapture |=>
      contextOut[AddrWidth-1:CtxTop] == $past(curContext[AddrWidth-1:CtxTop])); // R10

endmodule

// File: rtl/vaddr_seg_front.sv
module vaddr_seg_front
  import segdec_pkg::*;
#(
  parameter int AddrWidth = 32,
  parameter int IdWidth   = 8,
  parameter int PairShift = 13,
  parameter int CtxLsb    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [AddrWidth-1:0] vaddr,
  input  logic                 isWrite,
  input  logic [1:0]           privMode,
  input  logic                 errLevel,
  input  logic [1:0]           tlbStatus,
  input  logic [AddrWidth-1:0] tlbPhys,
  input  logic                 tlbWrOk,
  input  logic [AddrWidth-1:0] curContext,
  input  logic [AddrWidth-1:0] curEntryHi,
  output logic                 tlbLookup,
  output logic [AddrWidth-1:0] physAddr,
  output logic                 permRead,
  output logic                 permWrite,
  output logic                 excValid,
  output logic [2:0]           excClass,
  output logic                 refill,
  output logic                 faultStrobe,
  output logic [AddrWidth-1:0] badAddrOut,
  output logic [AddrWidth-1:0] contextOut,
  output logic [AddrWidth-1:0] entryHiOut
);

  ctrl_strobe_t ctrlStrobe;
  exc_e         excCode;

  segdec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .segBits   (vaddr[AddrWidth-1 -: 3]),
    .isWrite   (isWrite),
    .privMode  (priv_e'(privMode)),
    .errLevel  (errLevel),
    .tlbStatus (tlb_e'(tlbStatus)),
    .tlbWrOk   (tlbWrOk),
    .strobe    (ctrlStrobe),
    .excClass  (excCode),
    .refill    (refill),
    .tlbLookup (tlbLookup)
  );

  segdec_dp #(
    .AddrWidth (AddrWidth),
    .IdWidth   (IdWidth),
    .PairShift (PairShift),
    .CtxLsb    (CtxLsb)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (ctrlStrobe),
    .vaddr       (vaddr),
    .tlbPhys     (tlbPhys),
    .curContext  (curContext),
    .curEntryHi  (curEntryHi),
    .physAddr    (physAddr),
    .permRead    (permRead),
    .permWrite   (permWrite),
    .faultStrobe (faultStrobe),
    .badAddrOut  (badAddrOut),
    .contextOut  (contextOut),
    .entryHiOut  (entryHiOut)
  );

  assign excClass = excCode;
  assign excValid = (excCode != EXC_NONE);

endmodule

// File: tb/vaddr_seg_front_tb.sv
module vaddr_seg_front_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] vaddr;
  logic        isWrite;
  logic [1:0]  privMode;
  logic        errLevel;
  logic [1:0]  tlbStatus;
  logic [31:0] tlbPhys;
  logic        tlbWrOk;
  logic [31:0] curContext;
  logic [31:0] curEntryHi;
  logic        tlbLookup;
  logic [31:0] physAddr;
  logic        permRead;
  logic        permWrite;
  logic        excValid;
  logic [2:0]  excClass;
  logic        refill;
  logic        faultStrobe;
  logic [31:0] badAddrOut;
  logic [31:0] contextOut;
  logic [31:0] entryHiOut;

  int nCmp = 0;
  int nBad = 0;

  logic [31:0] mBad = '0;
  logic [31:0] mCtx = '0;
  logic [31:0] mEhi = '0;

  always #10 clk = ~clk;

  vaddr_seg_front u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .isWrite(isWrite), .privMode(privMode), .errLevel(errLevel),
    .tlbStatus(tlbStatus), .tlbPhys(tlbPhys), .tlbWrOk(tlbWrOk),
    .curContext(curContext), .curEntryHi(curEntryHi),
    .tlbLookup(tlbLookup), .physAddr(physAddr), .permRead(permRead),
    .permWrite(permWrite), .excValid(excValid), .excClass(excClass),
    .refill(refill), .faultStrobe(faultStrobe), .badAddrOut(badAddrOut),
    .contextOut(contextOut), .entryHiOut(entryHiOut)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model of the combinational outputs
  task automatic refModel(
    input  logic [31:0] a, input logic w, input logic [1:0] m, input logic el,
    input  logic [1:0] st, input logic [31:0] tp, input logic wok,
    output logic [31:0] ePhys, output logic eRd, output logic eWr,
    output logic [2:0] eExc, output logic eRefill, output logic eLook,
    output string tag);
    logic kern;
    logic open;
    logic useTlb;
    kern = m[1];
    ePhys = '0; eRd = 0; eWr = 0; eExc = 0; eRefill = 0; eLook = 0;
    useTlb = 0; open = 1;
    tag = "R1";
    if (!a[31]) begin
      if (el) begin
        ePhys = a; eRd = 1; eWr = 1; tag = "R2";
      end else useTlb = 1;
    end else if (a[31:29] == 3'b100) begin
      tag = "R3"; open = kern;
      if (kern) begin ePhys = a - 32'h8000_0000; eRd = 1; eWr = 1; end
    end else if (a[31:29] == 3'b101) begin
      tag = "R4"; open = kern;
      if (kern) begin ePhys = a - 32'hA000_0000; eRd = 1; eWr = 1; end
    end else begin
      tag = "R5";
      open = (a[29] == 1'b0) ? (kern || m == 2'd1) : kern;
      useTlb = open;
    end
    if (!open) begin
      eExc = w ? 3'd2 : 3'd1; tag = "R6";
    end else if (useTlb) begin
      eLook = 1;
      case (st)
        2'd0: begin ePhys = tp; eRd = 1; eWr = wok; end
        2'd1: begin eExc = w ? 3'd4 : 3'd3; eRefill = 1; tag = "R7"; end
        2'd2: begin eExc = w ? 3'd4 : 3'd3; tag = "R7"; end
        default: begin eExc = 3'd5; tag = "R8"; end
      endcase
    end
  endtask

  // Drive at a falling edge, check combinational results, then registered ones
  task automatic runOp(input logic rv, input logic [31:0] a, input logic w,
                       input logic [1:0] m, input logic el, input logic [1:0] st,
                       input logic [31:0] tp, input logic wok,
                       input logic [31:0] cc, input logic [31:0] ce);
    logic [31:0] ePhys;
    logic eRd, eWr, eRefill, eLook, eStrobe;
    logic [2:0] eExc;
    string tag;
    reqValid = rv; vaddr = a; isWrite = w; privMode = m; errLevel = el;
    tlbStatus = st; tlbPhys = tp; tlbWrOk = wok; curContext = cc; curEntryHi = ce;
    #5;
    refModel(a, w, m, el, st, tp, wok, ePhys, eRd, eWr, eExc, eRefill, eLook, tag);
    chk(tag, "physAddr", physAddr, ePhys);
    chk(tag, "permRead", 32'(permRead), 32'(eRd));
    chk(tag, "permWrite", 32'(permWrite), 32'(eWr));
    chk(tag, "excClass", 32'(excClass), 32'(eExc));
    chk(tag, "excValid", 32'(excValid), 32'(eExc != 0));
    chk(tag, "refill", 32'(refill), 32'(eRefill));
    chk(tag, "tlbLookup", 32'(tlbLookup), 32'(eLook));
    eStrobe = rv && (eExc != 0);
    if (eStrobe) begin
      mBad = a;
      mCtx = (cc & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
      mEhi = (ce & 32'h0000_00FF) | (a & 32'hFFFF_E000);
    end
    @(negedge clk);
    chk(eStrobe ? "R9" : "R12", "faultStrobe", 32'(faultStrobe), 32'(eStrobe));
    chk(eStrobe ? "R9" : "R12", "badAddrOut", badAddrOut, mBad);
    chk(eStrobe ? "R10" : "R12", "contextOut", contextOut, mCtx);
    chk(eStrobe ? "R11" : "R12", "entryHiOut", entryHiOut, mEhi);
  endtask

  initial begin
    #(20 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [31:0] bounds [9];
    logic [31:0] ra;
    void'($urandom(32'd20240611));
    rstN = 0; reqValid = 1; vaddr = 32'h8000_0000; isWrite = 0; privMode = 0;
    errLevel = 0; tlbStatus = 1; tlbPhys = '0; tlbWrOk = 0;
    curContext = '1; curEntryHi = '1;
    repeat (3) @(negedge clk);
    // R13: images cleared in reset even with a faulting input
    chk("R13", "faultStrobe", 32'(faultStrobe), 32'd0);
    chk("R13", "badAddrOut", badAddrOut, 32'd0);
    chk("R13", "contextOut", contextOut, 32'd0);
    chk("R13", "entryHiOut", entryHiOut, 32'd0);
    rstN = 1;
    reqValid = 0;
    @(negedge clk);

    // Directed corners
    bounds[0] = 32'h0000_0000; bounds[1] = 32'h7FFF_FFFF; bounds[2] = 32'h8000_0000;
    bounds[3] = 32'h9FFF_FFFF; bounds[4] = 32'hA000_0000; bounds[5] = 32'hBFFF_FFFF;
    bounds[6] = 32'hC000_0000; bounds[7] = 32'hDFFF_FFFF; bounds[8] = 32'hE000_0000;
    for (int b = 0; b < 9; b++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
          runOp(1'b1, bounds[b], s[0], m[1:0], 1'b0, s[1:0], 32'h1234_5000, s[1],
                32'hDEAD_BEEF, 32'hCAFE_F00D);
    // R2: error-level flag on low region ignores a missing entry
    runOp(1'b1, 32'h1234_5678, 1'b1, 2'd0, 1'b1, 2'd1, 32'h0, 1'b0, 32'h0, 32'h0);
    // R2: error-level flag has no effect above the low region
    runOp(1'b1, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b1, 2'd0, 32'h0, 1'b0, 32'h0, 32'h0);
    runOp(1'b1, 32'hFFFF_F123, 1'b1, 2'd3, 1'b1, 2'd3, 32'h0, 1'b0, 32'h0, 32'h7F);
    // R12: fault without reqValid leaves images alone
    runOp(1'b0, 32'hC000_1000, 1'b1, 2'd0, 1'b0, 2'd1, 32'h0, 1'b0, 32'h0, 32'h0);

    // Random stimulus
    for (int i = 0; i < 3000; i++) begin
      ra = $urandom;
      runOp(($urandom % 5) != 0, ra, ra[5] ^ ra[17], 2'($urandom),
            ($urandom % 4) == 0, 2'($urandom), $urandom, 1'($urandom),
            $urandom, $urandom);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule